// File: doc/BRIEF.md
# Slope-Compensation Ramp Reference with Qualified Trip

This block produces the reference level for peak-current-mode control of one power-stage phase. Its reference runs in one of two modes. In the first it is a static programmed level. In the second it is a falling ramp that restarts at a programmed start value whenever a selected PWM period-start pulse arrives, and then drops by a fixed step on every clock. The block compares a digitized current-sense word against this reference and reports a trip only after the comparison has held for several consecutive clocks. Once a trip has been qualified, the ramp stops where it is until the next period start.

The decrement step is written into a shadow holding register at any time. It moves into the working step only at a period start, so the slope never changes partway through a ramp. A polarity control can invert the raw comparison. A select input chooses which of several period-start pulses restarts this channel. Several instances can serve several interleaved phases.

Top module: `slope_ramp_trip`

## Requirements
- R1: While rst_n is low, ref_o is 0 and trip_o is 0.
- R2: With mode_ramp_i = 0 (fixed reference), ref_o equals the start_val_i sampled at the previous clock edge, whatever the sync, step and trip activity.
- R3: At a clock edge where the selected sync bit is 1, ref_o loads start_val_i, the ramp freeze is released and the qualification count clears, so trip_o is 0 after that edge.
- R4: Only sync_i[sync_sel_i] restarts the ramp and the other sync bits are ignored. A sync_sel_i value of NSYNC or above selects no input.
- R5: step_wr_i = 1 stores step_i into the shadow step. The working step takes the shadow value only at a selected sync edge. A shadow write in the same cycle as a sync reaches the working step only at the following sync.
- R6: In ramp mode, between syncs and without a trip, ref_o falls by the working step at each clock edge and stops at 0 instead of wrapping.
- R7: The raw compare is active when sense_i > ref_o (equality is inactive). With invert_i = 1 the active sense is inverted, so it is active when sense_i <= ref_o.
- R8: trip_o becomes 1 after the clock edge that completes QUAL (default 4) consecutive active compare samples, and it stays 1 while the compare stays active.
- R9: One inactive compare sample clears the qualification count. trip_o is 0 after that edge, and a fresh run of QUAL active samples is needed.
- R10: In ramp mode, ref_o holds its value from the first cycle in which trip_o is 1 until the next selected sync, even if trip_o later falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | NSYNC | Period-start pulses from the PWM channels |
| sync_sel_i | input | SELW | Index of the sync bit that restarts this ramp |
| mode_ramp_i | input | 1 | 0: fixed reference, 1: falling ramp |
| start_val_i | input | DW | Fixed reference level, or ramp start value |
| step_wr_i | input | 1 | Write strobe for the shadow step |
| step_i | input | DW | New decrement step for the shadow |
| invert_i | input | 1 | Inverts the raw compare result |
| sense_i | input | DW | Digitized current-sense sample |
| ref_o | output | DW | Present reference value |
| trip_o | output | 1 | Qualified trip flag |

## Verification
The assertions assume that reset is held for at least one clock before release, and that every input is stable and known at each clock edge. A sync pulse is therefore seen exactly once per edge at which it is high. The bench changes inputs only one time unit after a rising edge and holds each sync bit for a single clock. It picks sense levels that sit well above or below the reference, or exactly equal to it, so that each compare sample has a known result while the ramp moves.

// File: rtl/srt_pkg.sv
package srt_pkg;

    // Reference source selected by the mode input
    typedef enum logic {
        REF_FIXED = 1'b0,
        REF_RAMP  = 1'b1
    } ref_src_e;

    // Default sizing shared by the block and its bench
    localparam int SRT_DW_DEF    = 12;
    localparam int SRT_NSYNC_DEF = 3;
    localparam int SRT_QUAL_DEF  = 4;

endpackage

// File: rtl/srt_sync_pick.sv
module srt_sync_pick #(
    parameter int NSYNC = 3,
    parameter int SELW  = 2
) (
    input  logic [NSYNC-1:0] sync_i,
    input  logic [SELW-1:0]  sel_i,
    output logic             hit_o
);

    logic [NSYNC-1:0] match;

    // One comparator per sync source; an index beyond NSYNC matches nothing
    for (genvar g = 0; g < NSYNC; g++) begin : g_match
        always_comb begin
            match[g] = sync_i[g] && (sel_i == SELW'(g));
        end
    end

    always_comb begin
        hit_o = |match;
    end

    always_comb begin
        assert ($onehot0(match)) else $error("AST_ONE_SOURCE failed"); // R4
    end

endmodule

// File: rtl/srt_trip_qual.sv
module srt_trip_qual #(
    parameter int DW   = 12,
    parameter int QUAL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [DW-1:0] sense_i,
    input  logic [DW-1:0] ref_i,
    input  logic          invert_i,
    output logic          trip_o
);

    localparam int          CW   = $clog2(QUAL + 1);
    localparam logic [CW-1:0] QMAX = CW'(QUAL);

    typedef struct packed {
        logic [CW-1:0] run;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     active;

    always_comb begin
        active = (sense_i > ref_i) ^ invert_i;
        st_d   = st_q;
        if (clr_i) begin
            st_d.run = '0;
        end else if (!active) begin
            st_d.run = '0;
        end else if (st_q.run != QMAX) begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_o = (st_q.run == QMAX);

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !active) |=> !trip_o); // R9
    AST_TRIP_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && active && trip_o) |=> trip_o); // R8
    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !trip_o); // R3
    AST_RISE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> $past(active)); // R8

endmodule

// File: rtl/srt_ramp_gen.sv
module srt_ramp_gen
    import srt_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          ramp_mode_i,
    input  logic [DW-1:0] start_i,
    input  logic          step_wr_i,
    input  logic [DW-1:0] step_i,
    input  logic          trip_i,
    output logic [DW-1:0] ref_o
);

    typedef struct packed {
        logic [DW-1:0] level;
        logic [DW-1:0] shadow;
        logic [DW-1:0] step;
        logic          freeze;
    } ramp_st_t;

    ramp_st_t  st_d, st_q;
    ref_src_e  src;
    logic      hold;
    logic [DW-1:0] fallen;

    always_comb begin
        src    = ref_src_e'(ramp_mode_i);
        hold   = st_q.freeze || trip_i;
        fallen = (st_q.level > st_q.step) ? (st_q.level - st_q.step) : '0;
        st_d   = st_q;

        if (step_wr_i) begin
            st_d.shadow = step_i;
        end

        if (load_i) begin
            st_d.level  = start_i;
            st_d.step   = st_q.shadow;
            st_d.freeze = 1'b0;
        end else begin
            st_d.freeze = hold;
            if (src == REF_FIXED) begin
                st_d.level = start_i;
            end else if (!hold) begin
                st_d.level = fallen;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_o = st_q.level;

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ref_o == $past(start_i))); // R3
    AST_FIXED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_mode_i |=> (ref_o == $past(start_i))); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_mode_i && !load_i) |=> (ref_o <= $past(ref_o))); // R6
    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_mode_i && !load_i && (st_q.freeze || trip_i)) |=> $stable(ref_o)); // R10
    AST_STEP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.step)); // R5

endmodule

// File: rtl/slope_ramp_trip.sv
module slope_ramp_trip
    import srt_pkg::*;
#(
    parameter int DW    = SRT_DW_DEF,
    parameter int NSYNC = SRT_NSYNC_DEF,
    parameter int QUAL  = SRT_QUAL_DEF,
    parameter int SELW  = (NSYNC > 1) ? $clog2(NSYNC + 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSYNC-1:0] sync_i,
    input  logic [SELW-1:0]  sync_sel_i,
    input  logic             mode_ramp_i,
    input  logic [DW-1:0]    start_val_i,
    input  logic             step_wr_i,
    input  logic [DW-1:0]    step_i,
    input  logic             invert_i,
    input  logic [DW-1:0]    sense_i,
    output logic [DW-1:0]    ref_o,
    output logic             trip_o
);

    logic          sync_hit;
    logic [DW-1:0] ref_w;
    logic          trip_w;

    srt_sync_pick #(
        .NSYNC (NSYNC),
        .SELW  (SELW)
    ) pick_i (
        .sync_i (sync_i),
        .sel_i  (sync_sel_i),
        .hit_o  (sync_hit)
    );

    srt_ramp_gen #(
        .DW (DW)
    ) ramp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sync_hit),
        .ramp_mode_i (mode_ramp_i),
        .start_i     (start_val_i),
        .step_wr_i   (step_wr_i),
        .step_i      (step_i),
        .trip_i      (trip_w),
        .ref_o       (ref_w)
    );

    srt_trip_qual #(
        .DW   (DW),
        .QUAL (QUAL)
    ) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sync_hit),
        .sense_i  (sense_i),
        .ref_i    (ref_w),
        .invert_i (invert_i),
        .trip_o   (trip_w)
    );

    assign ref_o  = ref_w;
    assign trip_o = trip_w;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!trip_o && (ref_o == '0))); // R1

endmodule

// File: tb/slope_ramp_trip_tb_top.sv
module slope_ramp_trip_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 12;
    localparam int NSYNC = 3;
    localparam int SELW  = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NSYNC-1:0] sync_i;
    logic [SELW-1:0]  sync_sel_i;
    logic             mode_ramp_i;
    logic [DW-1:0]    start_val_i;
    logic             step_wr_i;
    logic [DW-1:0]    step_i;
    logic             invert_i;
    logic [DW-1:0]    sense_i;
    logic [DW-1:0]    ref_o;
    logic             trip_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slope_ramp_trip #(
        .DW    (DW),
        .NSYNC (NSYNC),
        .QUAL  (4)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .sync_sel_i  (sync_sel_i),
        .mode_ramp_i (mode_ramp_i),
        .start_val_i (start_val_i),
        .step_wr_i   (step_wr_i),
        .step_i      (step_i),
        .invert_i    (invert_i),
        .sense_i     (sense_i),
        .ref_o       (ref_o),
        .trip_o      (trip_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_sync(input logic [NSYNC-1:0] bits);
        sync_i = bits;
        tick();
        sync_i = '0;
    endtask

    task automatic write_step(input int v);
        step_wr_i = 1'b1;
        step_i    = DW'(v);
        tick();
        step_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        ticks(3);
        chk("R1 ref", int'(ref_o), 0);
        chk("R1 trip", int'(trip_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_shadow();
        mode_ramp_i = 1'b1;
        sync_sel_i  = 2'd0;
        start_val_i = 12'd100;
        write_step(5);
        chk("R5 shadow not active", int'(ref_o), 0);
        pulse_sync(3'b001);
        chk("R3 reload", int'(ref_o), 100);
        ticks(3);
        chk("R6 ramp fall", int'(ref_o), 85);
        write_step(10);
        chk("R5 old step kept", int'(ref_o), 80);
        tick();
        chk("R5 old step kept 2", int'(ref_o), 75);
        step_wr_i = 1'b1;
        step_i    = 12'd20;
        pulse_sync(3'b001);
        step_wr_i = 1'b0;
        chk("R3 reload 2", int'(ref_o), 100);
        tick();
        chk("R5 same-cycle write deferred", int'(ref_o), 90);
        pulse_sync(3'b001);
        tick();
        chk("R5 deferred write applied", int'(ref_o), 80);
    endtask

    task automatic t_saturate();
        write_step(5);
        start_val_i = 12'd12;
        pulse_sync(3'b001);
        chk("R6 start", int'(ref_o), 12);
        tick();
        chk("R6 12-5", int'(ref_o), 7);
        tick();
        chk("R6 7-5", int'(ref_o), 2);
        tick();
        chk("R6 saturate", int'(ref_o), 0);
        tick();
        chk("R6 stays zero", int'(ref_o), 0);
    endtask

    task automatic t_select();
        start_val_i = 12'd200;
        sync_sel_i  = 2'd1;
        pulse_sync(3'b001);
        chk("R4 other sync ignored", int'(ref_o), 0);
        pulse_sync(3'b010);
        chk("R4 selected sync", int'(ref_o), 200);
        tick();
        chk("R4 ramp after select", int'(ref_o), 195);
        sync_sel_i = 2'd3;
        pulse_sync(3'b111);
        chk("R4 out of range selects none", int'(ref_o), 190);
        sync_sel_i = 2'd0;
    endtask

    task automatic t_fixed();
        mode_ramp_i = 1'b0;
        start_val_i = 12'd300;
        tick();
        chk("R2 fixed level", int'(ref_o), 300);
        start_val_i = 12'd250;
        pulse_sync(3'b001);
        chk("R2 fixed follows", int'(ref_o), 250);
        sense_i = 12'd4000;
        ticks(5);
        chk("R2 trip in fixed", int'(trip_o), 1);
        chk("R2 level unaffected by trip", int'(ref_o), 250);
        sense_i = 12'd0;
        tick();
    endtask

    task automatic t_qual();
        mode_ramp_i = 1'b1;
        write_step(1);
        start_val_i = 12'd1000;
        pulse_sync(3'b001);
        chk("R3 trip cleared by sync", int'(trip_o), 0);
        chk("R3 reload qual", int'(ref_o), 1000);
        sense_i = 12'd2000;
        ticks(3);
        chk("R8 no trip after 3", int'(trip_o), 0);
        chk("R6 falling", int'(ref_o), 997);
        tick();
        chk("R8 trip after 4", int'(trip_o), 1);
        chk("R10 frozen level", int'(ref_o), 996);
        ticks(2);
        chk("R8 trip held", int'(trip_o), 1);
        chk("R10 held", int'(ref_o), 996);
        sense_i = 12'd0;
        tick();
        chk("R9 trip drops", int'(trip_o), 0);
        tick();
        chk("R10 held after drop", int'(ref_o), 996);
        pulse_sync(3'b001);
        tick();
        chk("R10 released by sync", int'(ref_o), 999);
    endtask

    task automatic t_clear();
        sense_i = 12'd2000;
        ticks(3);
        sense_i = 12'd0;
        tick();
        sense_i = 12'd2000;
        ticks(3);
        chk("R9 run restarted", int'(trip_o), 0);
        tick();
        chk("R9 fresh run trips", int'(trip_o), 1);
        sense_i = 12'd0;
        tick();
        pulse_sync(3'b001);
    endtask

    task automatic t_invert();
        mode_ramp_i = 1'b0;
        start_val_i = 12'd500;
        sense_i     = 12'd500;
        invert_i    = 1'b0;
        ticks(5);
        chk("R7 equal is inactive", int'(trip_o), 0);
        invert_i = 1'b1;
        ticks(4);
        chk("R7 inverted equal active", int'(trip_o), 1);
        sense_i = 12'd501;
        tick();
        chk("R7 inverted above inactive", int'(trip_o), 0);
        invert_i = 1'b0;
        sense_i  = 12'd0;
    endtask

    initial begin
        sync_i = '0; sync_sel_i = '0; mode_ramp_i = 1'b0; start_val_i = '0;
        step_wr_i = 1'b0; step_i = '0; invert_i = 1'b0; sense_i = '0;
        t_reset();
        t_shadow();
        t_saturate();
        t_select();
        t_fixed();
        t_qual();
        t_clear();
        t_invert();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule